// File: doc/BRIEF.md
# Quadrature Oscillator with Interpolated Sine Table

This block is a numerically controlled oscillator that produces a sine word, a cosine word and a one-bit square wave from one phase accumulator. On each enabled clock a frequency tuning word is added to the phase. The phase is an unsigned binary fraction of one turn. Wraparound therefore comes from the adder overflowing, and no radian or degree scaling is needed anywhere.

The upper phase bits select an entry in a small table of sine samples and in a matching table of slopes. The next bits form a fraction that scales the slope, which gives linear interpolation between neighbouring samples. The cosine lane uses the same tables on the phase advanced by a quarter turn, so the block needs only two multipliers, one per lane. The square wave is the top phase bit, delayed so that it lines up with the two trigonometric outputs. A downconverter can use the sine and cosine words as a quadrature local oscillator, or use the square bit as a low-cost one.

Top module: `quad_nco`

## Requirements
- R1: With `stepEn` high and `phaseClear` low, each rising clock edge sets the phase to the old phase plus `tuneWord`, modulo 2^32.
- R2: With `stepEn` low and `phaseClear` low, the phase keeps its value, so all three outputs settle and then hold steady whatever `tuneWord` is.
- R3: With `phaseClear` high, the next rising edge loads a phase of zero. This takes priority over `stepEn`.
- R4: `squareOut` equals phase bit 31, taken from the same phase as the sine and cosine words.
- R5: The table holds 128 samples S[k] = round(32767·sin(2πk/128)), with rounding to the nearest integer and ties away from zero. Phase bits 31..25 give k. When phase bits 24..15 are zero, the sine output equals S[k] exactly.
- R6: The sine output is S[k] + floor(((S[(k+1) mod 128] − S[k])·f + 512) / 1024), where f is phase bits 24..15.
- R7: The cosine output is the R6 function applied to the phase plus 2^30, modulo 2^32.
- R8: The phase register value held during cycle c appears at the sine, cosine and square outputs during cycle c+3.
- R9: The sine and cosine words are two's complement and are clamped to the range −32767..+32767, so the code 0x8000 never appears.
- R10: While reset is asserted, the phase is zero and all outputs are zero. They stay zero for the first three cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stepEn | input | 1 | Adds the tuning word to the phase on this edge |
| phaseClear | input | 1 | Loads zero into the phase on this edge |
| tuneWord | input | 32 | Phase increment per enabled clock, in units of 2^-32 turn |
| sinOut | output | 16 | Signed sine word |
| cosOut | output | 16 | Signed cosine word |
| squareOut | output | 1 | Top phase bit, aligned with the sine and cosine words |

## Verification
The hardest case to reach from the ports is every combination of table index and interpolation fraction. Those are the points where a wrong slope, a wrong rounding bias or a slip at the table wrap from entry 127 back to entry 0 would show up. The bench clears the phase and then steps it by exactly one fraction unit (2^15) per clock for a full turn. This visits all 131072 lookup points in both lanes and compares each output against arithmetic done in the bench. Coarse, odd-valued and negative tuning words, enable gaps and mid-run clears then exercise the accumulator, the priority of the clear and the three-cycle alignment.

// File: rtl/quad_nco_pkg.sv
package quad_nco_pkg;

  localparam real TWO_PI = 6.283185307179586;

  typedef struct packed {
    logic clearPhase;
    logic stepPhase;
  } phaseCtl_t;

  // Taylor series for sine on [0, pi/2)
  function automatic real seriesSin(real x);
    real term;
    real acc;
    term = x;
    acc  = x;
    for (int n = 1; n < 11; n++) begin
      term = -term * x * x / (real'(2 * n) * real'(2 * n + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // Taylor series for cosine on [0, pi/2)
  function automatic real seriesCos(real x);
    real term;
    real acc;
    term = 1.0;
    acc  = 1.0;
    for (int n = 1; n < 11; n++) begin
      term = -term * x * x / (real'(2 * n - 1) * real'(2 * n));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // Scaled sine sample k of an n-entry table, n divisible by four
  function automatic int tableSample(int k, int n, int amp);
    int  wrapped;
    int  quarter;
    int  quadrant;
    int  rest;
    real angle;
    real unitVal;
    wrapped  = k % n;
    quarter  = n / 4;
    quadrant = wrapped / quarter;
    rest     = wrapped % quarter;
    angle    = TWO_PI * real'(rest) / real'(n);
    case (quadrant)
      0:       unitVal = seriesSin(angle);
      1:       unitVal = seriesCos(angle);
      2:       unitVal = -seriesSin(angle);
      default: unitVal = -seriesCos(angle);
    endcase
    return int'(real'(amp) * unitVal);
  endfunction

endpackage

// File: rtl/quad_nco_ctrl.sv
module quad_nco_ctrl
  import quad_nco_pkg::*;
(
  input  logic      stepEn,
  input  logic      phaseClear,
  output phaseCtl_t ctl
);

  // Clear wins over stepping
  always_comb begin
    ctl.clearPhase = phaseClear;
    ctl.stepPhase  = stepEn && !phaseClear;
  end

endmodule

// File: rtl/quad_nco_lane.sv
module quad_nco_lane
  import quad_nco_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int FRAC_W = 10,
  parameter int OUT_W  = 16,
  parameter int OFFSET = 0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [IDX_W+FRAC_W-1:0]      lookupPhase,
  output logic signed [OUT_W-1:0]      value
);

  localparam int LOOK_W     = IDX_W + FRAC_W;
  localparam int TBL_N      = 1 << IDX_W;
  localparam int FULL_SCALE = (1 << (OUT_W - 1)) - 1;
  localparam int PROD_W     = OUT_W + FRAC_W + 1;
  localparam int SUM_W      = OUT_W + 2;
  localparam logic [LOOK_W-1:0] OFFSET_W = LOOK_W'(OFFSET);
  localparam logic signed [PROD_W-1:0] ROUND_BIAS = PROD_W'(1 << (FRAC_W - 1));
  localparam logic signed [SUM_W-1:0]  POS_LIM = SUM_W'(FULL_SCALE);
  localparam logic signed [SUM_W-1:0]  NEG_LIM = -SUM_W'(FULL_SCALE);

  logic signed [OUT_W-1:0] sampleTbl [TBL_N];
  logic signed [OUT_W-1:0] slopeTbl  [TBL_N];

  for (genvar k = 0; k < TBL_N; k++) begin : g_tbl
    localparam int SAMPLE_HERE = tableSample(k, TBL_N, FULL_SCALE);
    localparam int SAMPLE_NEXT = tableSample(k + 1, TBL_N, FULL_SCALE);
    assign sampleTbl[k] = OUT_W'(SAMPLE_HERE);
    assign slopeTbl[k]  = OUT_W'(SAMPLE_NEXT - SAMPLE_HERE);
  end

  logic [LOOK_W-1:0] shiftedPhase;

  if (OFFSET == 0) begin : g_plain
    assign shiftedPhase = lookupPhase;
  end else begin : g_offset
    assign shiftedPhase = lookupPhase + OFFSET_W;
  end

  logic [IDX_W-1:0]  tblIdx;
  logic [FRAC_W-1:0] tblFrac;
  assign tblIdx  = shiftedPhase[LOOK_W-1 -: IDX_W];
  assign tblFrac = shiftedPhase[FRAC_W-1:0];

  // Stage 1: table read
  logic signed [OUT_W-1:0] baseS1;
  logic signed [OUT_W-1:0] slopeS1;
  logic [FRAC_W-1:0]       fracS1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseS1  <= '0;
      slopeS1 <= '0;
      fracS1  <= '0;
    end else begin
      baseS1  <= sampleTbl[tblIdx];
      slopeS1 <= slopeTbl[tblIdx];
      fracS1  <= tblFrac;
    end
  end

  // Stage 2: the single multiply of this lane
  logic signed [PROD_W-1:0] slopeExt;
  logic [PROD_W-1:0]        fracExt;
  logic signed [PROD_W-1:0] prodNext;
  logic signed [OUT_W-1:0]  baseS2;
  logic signed [PROD_W-1:0] prodS2;

  always_comb begin
    slopeExt = PROD_W'(slopeS1);
    fracExt  = PROD_W'(fracS1);
    prodNext = slopeExt * $signed(fracExt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseS2 <= '0;
      prodS2 <= '0;
    end else begin
      baseS2 <= baseS1;
      prodS2 <= prodNext;
    end
  end

  // Stage 3: round, add, clamp
  logic signed [PROD_W-1:0] biased;
  logic signed [PROD_W-1:0] scaled;
  logic signed [SUM_W-1:0]  total;
  logic signed [OUT_W-1:0]  clamped;

  always_comb begin
    biased = prodS2 + ROUND_BIAS;
    scaled = biased >>> FRAC_W;
    total  = SUM_W'(baseS2) + SUM_W'(scaled);
    if (total > POS_LIM) begin
      clamped = OUT_W'(POS_LIM);
    end else if (total < NEG_LIM) begin
      clamped = OUT_W'(NEG_LIM);
    end else begin
      clamped = OUT_W'(total);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      value <= '0;
    end else begin
      value <= clamped;
    end
  end

endmodule

// File: rtl/quad_nco_datapath.sv
module quad_nco_datapath
  import quad_nco_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 7,
  parameter int FRAC_W  = 10,
  parameter int OUT_W   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  phaseCtl_t                  ctl,
  input  logic [PHASE_W-1:0]         tuneWord,
  output logic [PHASE_W-1:0]         phaseNow,
  output logic signed [OUT_W-1:0]    sinOut,
  output logic signed [OUT_W-1:0]    cosOut,
  output logic                       squareOut
);

  localparam int LOOK_W     = IDX_W + FRAC_W;
  localparam int LANE_DELAY = 3;
  localparam int LANE_N     = 2;
  localparam int QUARTER    = 1 << (LOOK_W - 2);

  logic [PHASE_W-1:0] phaseAcc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseAcc <= '0;
    end else if (ctl.clearPhase) begin
      phaseAcc <= '0;
    end else if (ctl.stepPhase) begin
      phaseAcc <= phaseAcc + tuneWord;
    end
  end

  assign phaseNow = phaseAcc;

  // Square bit delayed to match the lanes
  logic [LANE_DELAY-1:0] sqPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sqPipe <= '0;
    end else begin
      sqPipe <= {sqPipe[LANE_DELAY-2:0], phaseAcc[PHASE_W-1]};
    end
  end

  assign squareOut = sqPipe[LANE_DELAY-1];

  logic signed [OUT_W-1:0] laneVal [LANE_N];

  // lane 0: sine, lane 1: cosine (quarter-turn advance)
  for (genvar lane = 0; lane < LANE_N; lane++) begin : g_lane
    quad_nco_lane #(
      .IDX_W (IDX_W),
      .FRAC_W(FRAC_W),
      .OUT_W (OUT_W),
      .OFFSET(lane * QUARTER)
    ) i_lane (
      .clk        (clk),
      .rstN       (rstN),
      .lookupPhase(phaseAcc[PHASE_W-1 -: LOOK_W]),
      .value      (laneVal[lane])
    );
  end

  assign sinOut = laneVal[0];
  assign cosOut = laneVal[1];

endmodule

// File: rtl/quad_nco.sv
module quad_nco
  import quad_nco_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 7,
  parameter int FRAC_W  = 10,
  parameter int OUT_W   = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stepEn,
  input  logic                    phaseClear,
  input  logic [PHASE_W-1:0]      tuneWord,
  output logic [OUT_W-1:0]        sinOut,
  output logic [OUT_W-1:0]        cosOut,
  output logic                    squareOut
);

  phaseCtl_t          ctl;
  logic [PHASE_W-1:0] phaseNow;
  logic signed [OUT_W-1:0] sinWord;
  logic signed [OUT_W-1:0] cosWord;

  quad_nco_ctrl i_ctrl (
    .stepEn    (stepEn),
    .phaseClear(phaseClear),
    .ctl       (ctl)
  );

  quad_nco_datapath #(
    .PHASE_W(PHASE_W),
    .IDX_W  (IDX_W),
    .FRAC_W (FRAC_W),
    .OUT_W  (OUT_W)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .tuneWord (tuneWord),
    .phaseNow (phaseNow),
    .sinOut   (sinWord),
    .cosOut   (cosWord),
    .squareOut(squareOut)
  );

  assign sinOut = sinWord;
  assign cosOut = cosWord;

endmodule

// File: rtl/quad_nco_checker.sv
module quad_nco_checker #(
  parameter int PHASE_W = 32,
  parameter int OUT_W   = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               stepEn,
  input logic               phaseClear,
  input logic [PHASE_W-1:0] tuneWord,
  input logic [PHASE_W-1:0] phaseNow,
  input logic [OUT_W-1:0]   sinOut,
  input logic [OUT_W-1:0]   cosOut,
  input logic               squareOut
);

  localparam logic [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  a_r1_accumulate: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !phaseClear) |=> (phaseNow == $past(phaseNow) + $past(tuneWord)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stepEn && !phaseClear) |=> $stable(phaseNow));

  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    phaseClear |=> (phaseNow == '0));

  a_r4_square_aligned: assert property (@(posedge clk) disable iff (!rstN)
    squareOut == $past(phaseNow[PHASE_W-1], 3));

  a_r9_no_most_negative: assert property (@(posedge clk) disable iff (!rstN)
    (sinOut != MOST_NEG) && (cosOut != MOST_NEG));

endmodule

bind quad_nco quad_nco_checker #(
  .PHASE_W(PHASE_W),
  .OUT_W  (OUT_W)
) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .stepEn    (stepEn),
  .phaseClear(phaseClear),
  .tuneWord  (tuneWord),
  .phaseNow  (phaseNow),
  .sinOut    (sinOut),
  .cosOut    (cosOut),
  .squareOut (squareOut)
);

// File: tb/test_quad_nco.sv
module test_quad_nco;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepEn = 1'b0;
  logic        phaseClear = 1'b0;
  logic [31:0] tuneWord = '0;
  logic [15:0] sinOut;
  logic [15:0] cosOut;
  logic        squareOut;

  quad_nco i_quad_nco (
    .clk       (clk),
    .rstN      (rstN),
    .stepEn    (stepEn),
    .phaseClear(phaseClear),
    .tuneWord  (tuneWord),
    .sinOut    (sinOut),
    .cosOut    (cosOut),
    .squareOut (squareOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [31:0] modelP = '0;
  logic [31:0] histP [3];
  bit          histV [3];

  // R5 table sample
  function automatic int tblS(int k);
    real ang;
    ang = 6.283185307179586 * real'(k % 128) / 128.0;
    return int'(32767.0 * $sin(ang));
  endfunction

  // R6 interpolation with R9 clamp
  function automatic int expectVal(logic [31:0] p);
    int k;
    int f;
    int s0;
    int s1;
    int v;
    k  = int'(p[31:25]);
    f  = int'(p[24:15]);
    s0 = tblS(k);
    s1 = tblS(k + 1);
    v  = s0 + (((s1 - s0) * f + 512) >>> 10);
    if (v > 32767) v = 32767;
    if (v < -32767) v = -32767;
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a falling edge; checks, then drives the next edge
  task automatic cycle(string tag, logic en, logic clr, logic [31:0] ftw);
    if (histV[2]) begin
      check(tag, int'($signed(sinOut)), expectVal(histP[2]));
      check("R7", int'($signed(cosOut)), expectVal(histP[2] + 32'h4000_0000));
      check("R4", int'(squareOut), int'(histP[2][31]));
    end else begin
      check("R10", int'(sinOut), 0);
      check("R10", int'(cosOut), 0);
      check("R10", int'(squareOut), 0);
    end
    check("R9", int'(sinOut == 16'h8000 || cosOut == 16'h8000), 0);
    histP[2] = histP[1];
    histV[2] = histV[1];
    histP[1] = histP[0];
    histV[1] = histV[0];
    histP[0] = modelP;
    histV[0] = 1'b1;
    stepEn     = en;
    phaseClear = clr;
    tuneWord   = ftw;
    if (clr) modelP = '0;
    else if (en) modelP = modelP + ftw;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) histV[i] = 1'b0;
    for (int i = 0; i < 3; i++) histP[i] = '0;
    // R10: outputs quiet under reset
    repeat (3) begin
      @(negedge clk);
      check("R10", int'(sinOut), 0);
      check("R10", int'(cosOut), 0);
      check("R10", int'(squareOut), 0);
    end
    rstN = 1'b1;

    // R8: abrupt start, latency of three
    for (int i = 0; i < 20; i++) cycle("R8", 1'b1, 1'b0, 32'h0123_4567);

    // R3: clear with step high, then with step low
    cycle("R3", 1'b1, 1'b1, 32'h1111_1111);
    for (int i = 0; i < 10; i++) cycle("R3", 1'b1, 1'b0, 32'h1111_1111);
    cycle("R3", 1'b0, 1'b1, 32'h0000_0000);
    cycle("R3", 1'b0, 1'b1, 32'h2222_2222);

    // R6: every index and fraction, one fraction unit per clock
    cycle("R6", 1'b0, 1'b1, 32'h0);
    for (int i = 0; i < 131072 + 8; i++) cycle("R6", 1'b1, 1'b0, 32'h0000_8000);

    // R5: one table entry per step, fraction zero
    cycle("R5", 1'b0, 1'b1, 32'h0);
    for (int i = 0; i < 260; i++) cycle("R5", 1'b1, 1'b0, 32'h0200_0000);

    // R1: odd increment, then a negative one
    for (int i = 0; i < 12000; i++) cycle("R1", 1'b1, 1'b0, 32'h0006_8A31);
    for (int i = 0; i < 4000; i++) cycle("R1", 1'b1, 1'b0, 32'hFFF9_75CF);

    // R2: no stepping, tuning word changing
    for (int i = 0; i < 300; i++) cycle("R2", 1'b0, 1'b0, 32'h9E37_79B9 * 32'(i));
    for (int i = 0; i < 900; i++) cycle("R2", (i % 3) == 0, 1'b0, 32'h0135_7531);

    // R4: square at half and quarter turn steps
    for (int i = 0; i < 40; i++) cycle("R4", 1'b1, 1'b0, 32'h8000_0000);
    for (int i = 0; i < 40; i++) cycle("R4", 1'b1, 1'b0, 32'h4000_0000);

    for (int i = 0; i < 4; i++) cycle("R8", 1'b0, 1'b0, 32'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule